// File: doc/BRIEF.md
# Word-to-Character Serializing Demultiplexer

This block takes 32-bit words delivered by a master that is clocked four times slower than the system clock and turns each word into four 8-bit characters. The characters leave on consecutive system-clock cycles, starting with the most significant byte. Each character is steered to one of three decryption-channel outputs. A select value held in a register bank picks the channel. Each channel has its own data bus and valid flag.

Each word is first captured on the master clock. The system-clock side notices it and spends two warm-up cycles in which no channel is valid and all data is zero. It then emits the four characters. If the master has captured another valid word by the time the last character leaves, that word is loaded at once and emission continues with no gap. Otherwise the block falls back to idle. By then its shift store has drained to zero.

Top module: `word_demux`

## Requirements
- R1: While rst_n is low, every channel's data is zero and every valid flag is low. After reset is released with no valid word presented, the outputs stay zero and no stale character from before the reset ever appears.
- R2: A word captured on the master-clock edge at fast edge E produces two fast cycles after edges E+1 and E+2 in which all channel valids are low and all channel data is zero.
- R3: The four characters of a word appear on the selected channel after fast edges E+3, E+4, E+5 and E+6, in the order bits [31:24], [23:16], [15:8], [7:0], with that channel's valid high on each of those cycles.
- R4: If another valid word is captured on the next master edge (E+4), its four characters follow after fast edges E+7 to E+10 with no idle cycle between the two words.
- R5: Select value 0, 1 or 2 routes each character to channel 0, 1 or 2 respectively, where channel c occupies ch_data_o[8c+7:8c] and ch_valid_o[c]. The two unselected channels keep valid low and data zero.
- R6: Select value 3 routes to no channel: all valid flags stay low and all data stays zero while characters are being emitted.
- R7: When no new valid word has been captured by the time the last character is emitted, the block returns to idle, and from the next cycle all outputs are zero and invalid.
- R8: An all-zero word presented with valid high is still emitted as four characters of value zero with the selected channel's valid high.
- R9: At most one channel valid flag is high in any cycle, and a channel whose valid is low always shows zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_master | input | 1 | Slow master clock, one quarter of the system clock rate and edge-aligned with it |
| clk_sys | input | 1 | System clock on which characters are emitted |
| rst_n | input | 1 | Asynchronous active-low reset for both clock sides |
| sel_i | input | 2 | Channel select from the register bank (3 = no channel) |
| data_i | input | 32 | Word from the master, sampled on clk_master |
| valid_i | input | 1 | Word-valid from the master, sampled on clk_master |
| ch_data_o | output | 24 | Packed channel data; channel c in bits [8c+7:8c] |
| ch_valid_o | output | 3 | Per-channel character valid, bit c for channel c |

## Verification
The bench builds the block with its default parameters: 32-bit words, 8-bit characters and three channels under a 2-bit select. With these values the unused select code 3 can be driven, as can each real channel in turn. The defaults also make it possible to check the exact cycle of every one of the four byte lanes against an edge-aligned master clock. The master and system clocks come from one generator, so a word can be placed on a chosen master edge. This makes the warm-up latency, the seamless hand-off between consecutive words and the return to idle observable on exact fast-clock cycles.

// File: rtl/wdmx_pkg.sv
package wdmx_pkg;

    typedef enum logic [1:0] {
        SER_IDLE = 2'd0,
        SER_WARM = 2'd1,
        SER_EMIT = 2'd2
    } ser_state_e;

endpackage

// File: rtl/wdmx_capture.sv
module wdmx_capture #(
    parameter int WORD_W = 32
) (
    input  logic              clk_master,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] data_i,
    input  logic              valid_i,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o
);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              vld;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d      = cap_q;
        cap_d.vld  = valid_i;
        cap_d.word = valid_i ? data_i : '0;
    end

    always_ff @(posedge clk_master or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign word_o  = cap_q.word;
    assign valid_o = cap_q.vld;

endmodule

// File: rtl/wdmx_serializer.sv
module wdmx_serializer
    import wdmx_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int CHAR_W = 8
) (
    input  logic              clk_sys,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] cap_word_i,
    input  logic              cap_valid_i,
    output logic [CHAR_W-1:0] char_o,
    output logic              emit_o
);

    localparam int NCHAR = WORD_W / CHAR_W;
    localparam int CNT_W = (NCHAR > 1) ? $clog2(NCHAR) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NCHAR - 1);

    typedef struct packed {
        ser_state_e        state;
        logic [WORD_W-1:0] store;
        logic [CNT_W-1:0]  idx;
    } ser_t;

    ser_t ser_d, ser_q;

    always_comb begin
        ser_d = ser_q;
        case (ser_q.state)
            SER_IDLE: begin
                if (cap_valid_i) begin
                    ser_d.state = SER_WARM;
                end
            end
            SER_WARM: begin
                ser_d.state = SER_EMIT;
                ser_d.store = cap_word_i;
                ser_d.idx   = '0;
            end
            SER_EMIT: begin
                ser_d.store = ser_q.store << CHAR_W;
                ser_d.idx   = ser_q.idx + 1'b1;
                if (ser_q.idx == LAST_IDX) begin
                    if (cap_valid_i) begin
                        ser_d.store = cap_word_i;
                        ser_d.idx   = '0;
                    end else begin
                        ser_d.state = SER_IDLE;
                    end
                end
            end
            default: begin
                ser_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk_sys or negedge rst_n) begin
        if (!rst_n) begin
            ser_q <= '0;
        end else begin
            ser_q <= ser_d;
        end
    end

    assign emit_o = (ser_q.state == SER_EMIT);
    assign char_o = ser_q.store[WORD_W-1 -: CHAR_W];

endmodule

// File: rtl/wdmx_router.sv
module wdmx_router #(
    parameter int CHAR_W = 8,
    parameter int NCH    = 3,
    parameter int SEL_W  = 2
) (
    input  logic                  clk_sys,
    input  logic                  rst_n,
    input  logic [SEL_W-1:0]      sel_i,
    input  logic [CHAR_W-1:0]     char_i,
    input  logic                  emit_i,
    output logic [NCH*CHAR_W-1:0] ch_data_o,
    output logic [NCH-1:0]        ch_valid_o
);

    typedef struct packed {
        logic [NCH*CHAR_W-1:0] data;
        logic [NCH-1:0]        vld;
    } rt_t;

    rt_t rt_d, rt_q;

    always_comb begin
        rt_d = '0;
        for (int c = 0; c < NCH; c++) begin
            if (emit_i && (sel_i == SEL_W'(c))) begin
                rt_d.vld[c]                   = 1'b1;
                rt_d.data[c*CHAR_W +: CHAR_W] = char_i;
            end
        end
    end

    always_ff @(posedge clk_sys or negedge rst_n) begin
        if (!rst_n) begin
            rt_q <= '0;
        end else begin
            rt_q <= rt_d;
        end
    end

    assign ch_data_o  = rt_q.data;
    assign ch_valid_o = rt_q.vld;

endmodule

// File: rtl/word_demux.sv
module word_demux #(
    parameter int WORD_W = 32,
    parameter int CHAR_W = 8,
    parameter int NCH    = 3,
    parameter int SEL_W  = 2
) (
    input  logic                  clk_master,
    input  logic                  clk_sys,
    input  logic                  rst_n,
    input  logic [SEL_W-1:0]      sel_i,
    input  logic [WORD_W-1:0]     data_i,
    input  logic                  valid_i,
    output logic [NCH*CHAR_W-1:0] ch_data_o,
    output logic [NCH-1:0]        ch_valid_o
);

    logic [WORD_W-1:0] cap_word_w;
    logic              cap_valid_w;
    logic [CHAR_W-1:0] char_w;
    logic              emit_w;

    wdmx_capture #(
        .WORD_W (WORD_W)
    ) u_capture (
        .clk_master (clk_master),
        .rst_n      (rst_n),
        .data_i     (data_i),
        .valid_i    (valid_i),
        .word_o     (cap_word_w),
        .valid_o    (cap_valid_w)
    );

    wdmx_serializer #(
        .WORD_W (WORD_W),
        .CHAR_W (CHAR_W)
    ) u_serializer (
        .clk_sys     (clk_sys),
        .rst_n       (rst_n),
        .cap_word_i  (cap_word_w),
        .cap_valid_i (cap_valid_w),
        .char_o      (char_w),
        .emit_o      (emit_w)
    );

    wdmx_router #(
        .CHAR_W (CHAR_W),
        .NCH    (NCH),
        .SEL_W  (SEL_W)
    ) u_router (
        .clk_sys    (clk_sys),
        .rst_n      (rst_n),
        .sel_i      (sel_i),
        .char_i     (char_w),
        .emit_i     (emit_w),
        .ch_data_o  (ch_data_o),
        .ch_valid_o (ch_valid_o)
    );

endmodule

// File: rtl/word_demux_checker.sv
module word_demux_checker #(
    parameter int CHAR_W = 8,
    parameter int NCH    = 3,
    parameter int SEL_W  = 2
) (
    input logic                  clk_sys,
    input logic                  rst_n,
    input logic [SEL_W-1:0]      sel_i,
    input logic                  emit,
    input logic [NCH*CHAR_W-1:0] ch_data_o,
    input logic [NCH-1:0]        ch_valid_o
);

    // R9: never two channels valid at once
    a_r9_single_channel: assert property (@(posedge clk_sys) disable iff (!rst_n)
        $onehot0(ch_valid_o));

    // R9: an idle channel shows zero data
    for (genvar c = 0; c < NCH; c++) begin : g_quiet
        a_r9_zero_when_idle: assert property (@(posedge clk_sys) disable iff (!rst_n)
            !ch_valid_o[c] |-> (ch_data_o[c*CHAR_W +: CHAR_W] == '0));
    end

    // R5: an emitted character reaches the channel that was selected
    a_r5_routed: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (emit && (sel_i < SEL_W'(NCH))) |=> ch_valid_o[$past(sel_i)]);

    // R6: an out-of-range select drives no channel
    a_r6_no_target: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (sel_i >= SEL_W'(NCH)) |=> (ch_valid_o == '0));

    // R2/R3: channel valid only ever follows an emitting serializer
    a_r2_valid_needs_emit: assert property (@(posedge clk_sys) disable iff (!rst_n)
        !emit |=> (ch_valid_o == '0));

endmodule

bind word_demux word_demux_checker #(
    .CHAR_W (CHAR_W),
    .NCH    (NCH),
    .SEL_W  (SEL_W)
) u_chk (
    .clk_sys    (clk_sys),
    .rst_n      (rst_n),
    .sel_i      (sel_i),
    .emit       (emit_w),
    .ch_data_o  (ch_data_o),
    .ch_valid_o (ch_valid_o)
);

// File: tb/word_demux_test.sv
module word_demux_test;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = CLK_PERIOD / 2;
    localparam int NVEC       = 6;

    // {sel, word}
    localparam logic [33:0] VEC [NVEC] = '{
        {2'd0, 32'hA1B2C3D4},
        {2'd1, 32'h11223344},
        {2'd2, 32'hDEADBEEF},
        {2'd3, 32'h55AA55AA},
        {2'd1, 32'h00000000},
        {2'd2, 32'h80000001}
    };

    logic        clk_master = 1'b0;
    logic        clk_sys    = 1'b0;
    logic        rst_n      = 1'b0;
    logic [1:0]  sel_i      = '0;
    logic [31:0] data_i     = '0;
    logic        valid_i    = 1'b0;
    logic [23:0] ch_data_o;
    logic [2:0]  ch_valid_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    word_demux uut (
        .clk_master (clk_master),
        .clk_sys    (clk_sys),
        .rst_n      (rst_n),
        .sel_i      (sel_i),
        .data_i     (data_i),
        .valid_i    (valid_i),
        .ch_data_o  (ch_data_o),
        .ch_valid_o (ch_valid_o)
    );

    // edge-aligned clocks, master at one quarter rate
    initial begin
        int ph = 0;
        forever begin
            #(HALF);
            clk_sys = 1'b1;
            if (ph == 0) clk_master = 1'b1;
            else if (ph == 2) clk_master = 1'b0;
            ph = (ph + 1) % 4;
            #(HALF);
            clk_sys = 1'b0;
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic check(input string req, input logic [2:0] ev, input logic [23:0] ed);
        n_checks++;
        if (ch_valid_o !== ev || ch_data_o !== ed) begin
            n_fail++;
            $display("FAIL %s: valid=%b data=%h expected valid=%b data=%h",
                     req, ch_valid_o, ch_data_o, ev, ed);
        end
    endtask

    function automatic logic [7:0] byte_of(input logic [31:0] w, input int i);
        return w[31 - 8*i -: 8];
    endfunction

    // expected outputs k fast edges after a word is captured, one word only
    task automatic expect_single(input int k, input logic [1:0] s, input logic [31:0] w,
                                 output logic [2:0] ev, output logic [23:0] ed);
        ev = '0;
        ed = '0;
        if (k >= 3 && k <= 6 && s < 2'd3) begin
            ev[s] = 1'b1;
            ed    = 24'(byte_of(w, k - 3)) << (8 * s);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        logic [2:0]  ev;
        logic [23:0] ed;

        // R1: reset state
        #1;
        check("R1 reset", 3'b000, 24'h0);
        repeat (3) @(posedge clk_sys);
        #2 rst_n = 1'b1;
        repeat (4) @(posedge clk_sys);
        #2 check("R1 idle after reset", 3'b000, 24'h0);

        // table walk: single words, R2 R3 R5 R6 R7 R8
        for (int v = 0; v < NVEC; v++) begin
            @(posedge clk_master);
            #1;
            sel_i   = VEC[v][33:32];
            data_i  = VEC[v][31:0];
            valid_i = 1'b1;
            @(posedge clk_master);
            #1;
            valid_i = 1'b0;
            data_i  = '0;
            for (int k = 1; k <= 7; k++) begin
                @(posedge clk_sys);
                #2;
                expect_single(k, VEC[v][33:32], VEC[v][31:0], ev, ed);
                if (k <= 2)      check("R2 warm-up", ev, ed);
                else if (k == 7) check("R7 back to idle", ev, ed);
                else if (VEC[v][33:32] == 2'd3) check("R6 no channel", ev, ed);
                else if (VEC[v][31:0] == 32'h0) check("R8 zero word", ev, ed);
                else             check("R3/R5 byte order and route", ev, ed);
            end
        end

        // R4: two words back to back on channel 1
        @(posedge clk_master);
        #1;
        sel_i   = 2'd1;
        data_i  = 32'hCAFEF00D;
        valid_i = 1'b1;
        @(posedge clk_master);
        #1;
        data_i = 32'h01234567;
        for (int k = 1; k <= 11; k++) begin
            @(posedge clk_sys);
            #1;
            if (k == 4) begin
                valid_i = 1'b0;
                data_i  = '0;
            end
            #1;
            ev = '0;
            ed = '0;
            if (k >= 3 && k <= 6) begin
                ev[1] = 1'b1;
                ed    = 24'(byte_of(32'hCAFEF00D, k - 3)) << 8;
            end else if (k >= 7 && k <= 10) begin
                ev[1] = 1'b1;
                ed    = 24'(byte_of(32'h01234567, k - 7)) << 8;
            end
            check("R4 back-to-back", ev, ed);
        end

        // R1: reset in mid-stream clears everything
        @(posedge clk_master);
        #1;
        sel_i   = 2'd0;
        data_i  = 32'h99887766;
        valid_i = 1'b1;
        @(posedge clk_master);
        #1;
        valid_i = 1'b0;
        data_i  = '0;
        repeat (3) @(posedge clk_sys);
        #2 check("R3 first byte before reset", 3'b001, 24'h000099);
        rst_n = 1'b0;
        #1 check("R1 async clear", 3'b000, 24'h0);
        @(posedge clk_sys);
        #2 rst_n = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(posedge clk_sys);
            #2 check("R1 no stale bytes", 3'b000, 24'h0);
        end

        finish_run();
    end

endmodule